// File: doc/BRIEF.md
# Flag Offset Programmer

This block holds the two threshold offsets that a FIFO's flag logic compares against: one sets how near to empty the almost-empty warning fires, the other how near to full the almost-full warning fires. It has no address inputs. A single active-low load select takes over the FIFO's own write and read ports. While the select is low, each enabled write clock edge stores the low bits of the write data into one offset register. Each enabled read clock edge copies one offset register onto the read data port. A pointer on each side alternates between the two registers, starting with the almost-empty offset.

While the load select is high, the enables pass through as normal FIFO write and read requests and the offsets do not change. Both offsets feed the flag logic continuously. A mode input chooses the timing of that feed. In one setting each offset goes straight through. In the other, each offset passes through one register clocked in the domain of the flag that uses it: the read clock for almost-empty, the write clock for almost-full.

Top module: `flag_offset_programmer`

## Requirements
- R1: After reset both offsets read 127 at `ae_offset` and `af_offset`, `rd_data` is 0, and both alternation pointers point at the almost-empty register.
- R2: With `load_n` low and `wr_en_n` low, successive `wr_clk` rising edges store into the almost-empty register, then the almost-full register, then the almost-empty register again, and so on.
- R3: With `load_n` low and `wr_en_n` high, a `wr_clk` edge changes neither offset and does not move the write pointer.
- R4: Raising `load_n` after one or two writes leaves any register that was not written at its old value. The write pointer keeps its position across the period with `load_n` high.
- R5: With `load_n` low and `rd_en_n` low, successive `rd_clk` edges place the almost-empty offset, then the almost-full offset, then the almost-empty offset on `rd_data`. The read pointer moves independently of the write pointer.
- R6: With `load_n` high, `fifo_wr_req` equals the inverse of `wr_en_n` and `fifo_rd_req` equals the inverse of `rd_en_n`. The offsets, `rd_data` and both pointers do not change. With `load_n` low, both request outputs are 0.
- R7: Only bits 15:0 of `wr_data` are stored. On readback, `rd_data` bits 17:16 are 0.
- R8: With `sync_flags` low, a stored value appears at its offset output right after the write edge. With `sync_flags` high, it appears one edge later in the flag's own domain: the `rd_clk` domain for `ae_offset`, the `wr_clk` domain for `af_offset`.
- R9: With `load_n` low and `rd_en_n` high, `rd_data` holds its value and the read pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst_n | input | 1 | Write-side synchronous reset, active low |
| rd_clk | input | 1 | Read-side clock |
| rd_rst_n | input | 1 | Read-side synchronous reset, active low |
| load_n | input | 1 | Offset access select, active low |
| sync_flags | input | 1 | 1 = offsets pass through a register in the flag's own domain |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | 18 | Write data; bits 15:0 are used for offsets |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | 18 | Registered offset readback |
| fifo_wr_req | output | 1 | Write request passed on to the FIFO |
| fifo_rd_req | output | 1 | Read request passed on to the FIFO |
| ae_offset | output | 16 | Almost-empty offset sent to the flag logic |
| af_offset | output | 16 | Almost-full offset sent to the flag logic |

## Verification
The assertions assume that the offset registers change only while the read side is not reading them back. Readback samples write-domain state without a synchronizer. They also assume that `sync_flags` is held steady for at least one edge before a check that depends on it. The stimulus drives both clock ports from one clock. It changes `load_n`, the enables and `sync_flags` only at falling edges, so every access is a clean single-edge event, and no readback happens in the same cycle as an offset write.

// File: rtl/ofs_prog_pkg.sv
// Shared types for the flag offset programmer.
// Assumes two offset registers only, selected by a one-bit pointer.
package ofs_prog_pkg;

    typedef enum logic {
        SEL_EMPTY = 1'b0,
        SEL_FULL  = 1'b1
    } ofs_sel_t;

    // Next register in the alternating access order.
    function automatic ofs_sel_t ofs_next(input ofs_sel_t cur);
        return (cur == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    endfunction

endpackage

// File: rtl/ofs_toggle_sel.sv
// Alternating register pointer for one clock domain.
// Moves to the other register on each qualified access and returns to
// the almost-empty register on reset. Assumes step is synchronous to clk.
module ofs_toggle_sel
    import ofs_prog_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     step,
    output ofs_sel_t sel
);

    // Advance the pointer once per access.
    always_ff @(posedge clk) begin
        if (!rst_n)    sel <= SEL_EMPTY;
        else if (step) sel <= ofs_next(sel);
    end

endmodule

// File: rtl/ofs_bank.sv
// Storage for the two offset registers, written in the write domain.
// Index 0 is the almost-empty offset and index 1 the almost-full offset.
// Assumes wr_val is already cut down to OFS_W bits by the caller.
module ofs_bank
    import ofs_prog_pkg::*;
#(
    parameter int OFS_W       = 16,
    parameter int DEFAULT_OFS = 127
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stb,
    input  ofs_sel_t         sel,
    input  logic [OFS_W-1:0] wr_val,
    output logic [OFS_W-1:0] lo_q,
    output logic [OFS_W-1:0] hi_q
);

    localparam int NREG = 2;
    localparam logic [OFS_W-1:0] RST_VAL = OFS_W'(DEFAULT_OFS);

    logic [OFS_W-1:0] regs [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        // Load entry g when the pointer selects it.
        always_ff @(posedge clk) begin
            if (!rst_n)                          regs[g] <= RST_VAL;
            else if (wr_stb && (int'(sel) == g)) regs[g] <= wr_val;
        end
    end

    assign lo_q = regs[0];
    assign hi_q = regs[1];

endmodule

// File: rtl/ofs_readback.sv
// Registered readback of the selected offset in the read domain.
// Zero-extends to the data width. Assumes DATA_W > OFS_W and that the
// offsets do not change in the cycle a readback samples them.
module ofs_readback
    import ofs_prog_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int OFS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  ofs_sel_t          sel,
    input  logic [OFS_W-1:0]  lo_q,
    input  logic [OFS_W-1:0]  hi_q,
    output logic [DATA_W-1:0] rd_data
);

    localparam int PAD_W = DATA_W - OFS_W;

    logic [OFS_W-1:0] pick;

    // Choose the register the read pointer names.
    always_comb pick = (sel == SEL_EMPTY) ? lo_q : hi_q;

    // Capture the chosen offset on a readback access; hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_stb) rd_data <= {{PAD_W{1'b0}}, pick};
    end

endmodule

// File: rtl/ofs_flag_stage.sv
// Presents one offset to the flag logic of one clock domain.
// With HAS_SYNC_PATH set, the value can pass through a register clocked
// in that domain, chosen at run time by sync_mode. Assumes sync_mode
// changes only rarely.
module ofs_flag_stage #(
    parameter int OFS_W         = 16,
    parameter int DEFAULT_OFS   = 127,
    parameter bit HAS_SYNC_PATH = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_mode,
    input  logic [OFS_W-1:0] val_in,
    output logic [OFS_W-1:0] val_out
);

    if (HAS_SYNC_PATH) begin : g_sync
        logic [OFS_W-1:0] staged;

        // Sample the offset on every edge of the flag's domain.
        always_ff @(posedge clk) begin
            if (!rst_n) staged <= OFS_W'(DEFAULT_OFS);
            else        staged <= val_in;
        end

        // Select the registered or the direct value.
        always_comb val_out = sync_mode ? staged : val_in;
    end else begin : g_direct
        // Direct feed only; the mode input has no effect here.
        always_comb val_out = val_in;
    end

endmodule

// File: rtl/flag_offset_programmer.sv
// Top of the flag offset programmer.
// While load_n is low, the FIFO enables address the two offset
// registers in alternating order, with separate pointers on the write
// and read sides. While load_n is high, the enables pass on to the FIFO.
// Assumes DATA_W > OFS_W and that each reset is synchronous to its clock.
module flag_offset_programmer
    import ofs_prog_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int OFS_W       = 16,
    parameter int DEFAULT_OFS = 127
) (
    input  logic              wr_clk,
    input  logic              wr_rst_n,
    input  logic              rd_clk,
    input  logic              rd_rst_n,
    input  logic              load_n,
    input  logic              sync_flags,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              fifo_wr_req,
    output logic              fifo_rd_req,
    output logic [OFS_W-1:0]  ae_offset,
    output logic [OFS_W-1:0]  af_offset
);

    localparam int PAD_W = DATA_W - OFS_W;

    logic             wr_prog;
    logic             rd_prog;
    ofs_sel_t         wsel;
    ofs_sel_t         rsel;
    logic [OFS_W-1:0] lo_q;
    logic [OFS_W-1:0] hi_q;
    logic [PAD_W-1:0] unused_hi_bits;

    // Split each enable between offset access and FIFO access.
    always_comb begin
        wr_prog     = !load_n && !wr_en_n;
        rd_prog     = !load_n && !rd_en_n;
        fifo_wr_req =  load_n && !wr_en_n;
        fifo_rd_req =  load_n && !rd_en_n;
    end

    // The data bits above the offset width are never stored.
    assign unused_hi_bits = wr_data[DATA_W-1:OFS_W];

    ofs_toggle_sel u_wsel (
        .clk   (wr_clk),
        .rst_n (wr_rst_n),
        .step  (wr_prog),
        .sel   (wsel)
    );

    ofs_toggle_sel u_rsel (
        .clk   (rd_clk),
        .rst_n (rd_rst_n),
        .step  (rd_prog),
        .sel   (rsel)
    );

    ofs_bank #(
        .OFS_W       (OFS_W),
        .DEFAULT_OFS (DEFAULT_OFS)
    ) u_bank (
        .clk    (wr_clk),
        .rst_n  (wr_rst_n),
        .wr_stb (wr_prog),
        .sel    (wsel),
        .wr_val (wr_data[OFS_W-1:0]),
        .lo_q   (lo_q),
        .hi_q   (hi_q)
    );

    ofs_readback #(
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_rdbk (
        .clk     (rd_clk),
        .rst_n   (rd_rst_n),
        .rd_stb  (rd_prog),
        .sel     (rsel),
        .lo_q    (lo_q),
        .hi_q    (hi_q),
        .rd_data (rd_data)
    );

    // The almost-empty flag lives in the read domain.
    ofs_flag_stage #(
        .OFS_W       (OFS_W),
        .DEFAULT_OFS (DEFAULT_OFS)
    ) u_ae_stage (
        .clk       (rd_clk),
        .rst_n     (rd_rst_n),
        .sync_mode (sync_flags),
        .val_in    (lo_q),
        .val_out   (ae_offset)
    );

    // The almost-full flag lives in the write domain.
    ofs_flag_stage #(
        .OFS_W       (OFS_W),
        .DEFAULT_OFS (DEFAULT_OFS)
    ) u_af_stage (
        .clk       (wr_clk),
        .rst_n     (wr_rst_n),
        .sync_mode (sync_flags),
        .val_in    (hi_q),
        .val_out   (af_offset)
    );

endmodule

// File: rtl/ofs_prog_chk.sv
// Checker for the flag offset programmer, bound to its top module.
// Assumes offsets are not written in a cycle that a readback samples.
module ofs_prog_chk
    import ofs_prog_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int OFS_W  = 16
) (
    input logic              wr_clk,
    input logic              wr_rst_n,
    input logic              rd_clk,
    input logic              rd_rst_n,
    input logic              load_n,
    input logic              sync_flags,
    input logic              wr_en_n,
    input logic [DATA_W-1:0] wr_data,
    input logic              rd_en_n,
    input logic [DATA_W-1:0] rd_data,
    input logic [OFS_W-1:0]  ae_offset,
    input logic [OFS_W-1:0]  af_offset,
    input ofs_sel_t          wsel,
    input ofs_sel_t          rsel,
    input logic [OFS_W-1:0]  lo_q,
    input logic [OFS_W-1:0]  hi_q
);

    // R2
    wsel_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!load_n && !wr_en_n) |=> (wsel != $past(wsel)));

    // R2
    lo_load_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!load_n && !wr_en_n && wsel == SEL_EMPTY) |=> (lo_q == $past(wr_data[OFS_W-1:0])));

    // R2
    hi_load_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (!load_n && !wr_en_n && wsel == SEL_FULL) |=> (hi_q == $past(wr_data[OFS_W-1:0])));

    // R3
    idle_hold_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (load_n || wr_en_n) |=> ($stable(lo_q) && $stable(hi_q) && $stable(wsel)));

    // R5
    rsel_step_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (!load_n && !rd_en_n) |=> (rsel != $past(rsel)));

    // R9
    rd_hold_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (load_n || rd_en_n) |=> ($stable(rd_data) && $stable(rsel)));

    // R8
    ae_sync_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
        (sync_flags && $past(sync_flags)) |-> (ae_offset == $past(lo_q)));

    // R8
    af_sync_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
        (sync_flags && $past(sync_flags)) |-> (af_offset == $past(hi_q)));

endmodule

bind flag_offset_programmer ofs_prog_chk #(
    .DATA_W (DATA_W),
    .OFS_W  (OFS_W)
) u_chk (
    .wr_clk     (wr_clk),
    .wr_rst_n   (wr_rst_n),
    .rd_clk     (rd_clk),
    .rd_rst_n   (rd_rst_n),
    .load_n     (load_n),
    .sync_flags (sync_flags),
    .wr_en_n    (wr_en_n),
    .wr_data    (wr_data),
    .rd_en_n    (rd_en_n),
    .rd_data    (rd_data),
    .ae_offset  (ae_offset),
    .af_offset  (af_offset),
    .wsel       (wsel),
    .rsel       (rsel),
    .lo_q       (lo_q),
    .hi_q       (hi_q)
);

// File: tb/flag_offset_programmer_test.sv
`timescale 1ns/1ps
module flag_offset_programmer_test;

    localparam int DW = 18;
    localparam int OW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_n = 1'b1;
    logic          sync_flags = 1'b0;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic [DW-1:0] rd_data;
    logic          fifo_wr_req;
    logic          fifo_rd_req;
    logic [OW-1:0] ae_offset;
    logic [OW-1:0] af_offset;

    int            n_vec = 0;
    int            n_bad = 0;
    bit            done = 1'b0;
    bit            rd_fired = 1'b0;
    logic [DW-1:0] exp_q[$];

    always #4 clk = ~clk;

    flag_offset_programmer uut (
        .wr_clk      (clk),
        .wr_rst_n    (rst_n),
        .rd_clk      (clk),
        .rd_rst_n    (rst_n),
        .load_n      (load_n),
        .sync_flags  (sync_flags),
        .wr_en_n     (wr_en_n),
        .wr_data     (wr_data),
        .rd_en_n     (rd_en_n),
        .rd_data     (rd_data),
        .fifo_wr_req (fifo_wr_req),
        .fifo_rd_req (fifo_rd_req),
        .ae_offset   (ae_offset),
        .af_offset   (af_offset)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Offset write: one enabled write edge with load_n low.
    task automatic wr_ofs(input logic [DW-1:0] d);
        @(negedge clk);
        load_n  = 1'b0;
        wr_en_n = 1'b0;
        wr_data = d;
        @(negedge clk);
        wr_en_n = 1'b1;
    endtask

    // Offset readback: push the expected word, then one enabled read edge.
    task automatic rd_ofs(input logic [DW-1:0] e);
        @(negedge clk);
        load_n  = 1'b0;
        rd_en_n = 1'b0;
        exp_q.push_back(e);
        @(posedge clk);
        #1 rd_fired = 1'b1;
        @(negedge clk);
        rd_en_n = 1'b1;
    endtask

    // Monitor: compare each readback with the head of the queue.
    always @(negedge clk) begin
        if (rd_fired) begin
            rd_fired = 1'b0;
            if (exp_q.size() == 0) chk("R5 queue underrun", 32'd1, 32'd0);
            else chk("R5 readback order", 32'(rd_data), 32'(exp_q.pop_front()));
        end
    end

    initial begin
        #(8 * 20000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 ae default", 32'(ae_offset), 32'd127);
        chk("R1 af default", 32'(af_offset), 32'd127);
        chk("R1 rd_data", 32'(rd_data), 32'd0);
        rd_ofs(18'd127);                 // R1: pointer starts at almost-empty
        rd_ofs(18'd127);

        // R2 / R7 / R8 async: write sequence, immediate effect
        wr_ofs(18'h3_0010);
        chk("R7 low bits only", 32'(ae_offset), 32'h0010);
        chk("R2 af untouched", 32'(af_offset), 32'd127);
        wr_ofs(18'h0_1234);
        chk("R2 second to full", 32'(af_offset), 32'h1234);
        wr_ofs(18'h0_0040);
        chk("R2 third to empty", 32'(ae_offset), 32'h0040);
        chk("R2 full kept", 32'(af_offset), 32'h1234);

        // R3: load low, write disabled
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            wr_data = 18'h2_AAAA;
        end
        @(negedge clk);
        chk("R3 ae stable", 32'(ae_offset), 32'h0040);
        chk("R3 af stable", 32'(af_offset), 32'h1234);

        // R6: normal operation passes enables to the FIFO
        load_n  = 1'b1;
        wr_en_n = 1'b0;
        rd_en_n = 1'b0;
        wr_data = 18'h0_5555;
        #1;
        chk("R6 fifo_wr_req", 32'(fifo_wr_req), 32'd1);
        chk("R6 fifo_rd_req", 32'(fifo_rd_req), 32'd1);
        repeat (2) @(negedge clk);
        chk("R6 ae unchanged", 32'(ae_offset), 32'h0040);
        chk("R6 af unchanged", 32'(af_offset), 32'h1234);
        chk("R6 rd_data unchanged", 32'(rd_data), 32'd127);
        wr_en_n = 1'b1;
        rd_en_n = 1'b1;
        load_n  = 1'b0;
        wr_en_n = 1'b0;
        #1;
        chk("R6 req blocked in load", 32'(fifo_wr_req), 32'd0);
        wr_en_n = 1'b1;
        load_n  = 1'b1;

        // R4: partial load resumes at the full register
        wr_ofs(18'h0_0777);
        load_n = 1'b1;
        chk("R4 full written", 32'(af_offset), 32'h0777);
        chk("R4 empty kept", 32'(ae_offset), 32'h0040);

        // R5 readback order, R6 read pointer untouched by normal reads
        rd_ofs(18'h0_0040);
        rd_ofs(18'h0_0777);
        rd_ofs(18'h0_0040);

        // R9 / R7: idle read holds zero-extended value
        @(negedge clk);
        load_n = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 rd_data hold", 32'(rd_data), 32'h0_0040);
        chk("R7 upper bits zero", 32'(rd_data[DW-1:OW]), 32'd0);

        // R8 synchronous mode: one extra edge
        sync_flags = 1'b1;
        repeat (2) @(negedge clk);
        wr_ofs(18'h0_0100);
        chk("R8 ae sync delay", 32'(ae_offset), 32'h0040);
        @(negedge clk);
        chk("R8 ae sync update", 32'(ae_offset), 32'h0100);
        wr_ofs(18'h0_0200);
        chk("R8 af sync delay", 32'(af_offset), 32'h0777);
        @(negedge clk);
        chk("R8 af sync update", 32'(af_offset), 32'h0200);
        rd_ofs(18'h0_0200);
        rd_ofs(18'h0_0100);

        // R1: reset mid-run restores defaults and pointers
        @(negedge clk);
        load_n = 1'b1;
        rst_n  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        chk("R1 ae after reset", 32'(ae_offset), 32'd127);
        chk("R1 af after reset", 32'(af_offset), 32'd127);
        chk("R1 rd_data after reset", 32'(rd_data), 32'd0);
        wr_ofs(18'h0_0033);
        @(negedge clk);
        chk("R1 write pointer reset", 32'(ae_offset), 32'h0033);
        chk("R1 af still default", 32'(af_offset), 32'd127);
        rd_ofs(18'h0_0033);
        repeat (2) @(negedge clk);
        chk("R5 queue drained", 32'(exp_q.size()), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule